// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns an addressing-mode code and the operand bytes of an instruction into the 24-bit address that the operand lives at. It serves a 16-bit processor core whose address space is split into 256 banks of 64 KiB. The other inputs are the core's register file contents: the direct-page base, the data bank, the program bank and counter, and the two index registers. The core pulses `start` with all inputs valid. One cycle later the unit pulses `done` with the address on `ea`.

The three indirect modes first read a pointer from bank 0. They issue one byte read per cycle through a request/valid port and assemble a 16-bit or 24-bit little-endian pointer. The address is formed from that pointer only after the last byte has arrived. While this happens `busy` is high and any further `start` is dropped. A `start` given in the same cycle as `done` is accepted, so operations can run back to back.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are low and `ea` is 0.
- R2: Mode 0 (immediate) gives `ea = {pbr, pc}`. For every mode that needs no pointer (codes 0-3 and 7-15), `done` is high in the cycle right after the `start` cycle.
- R3: Mode 1 (direct) gives `ea = {8'h00, (dp + opnd[7:0]) mod 2^16}`.
- R4: Mode 2 (absolute) gives `ea = {dbr, opnd[15:0]}`. Mode 3 (absolute long) gives `ea = opnd`. The unused codes 12-15 behave as mode 3.
- R5: Modes 7 and 8 (direct page plus X, direct page plus Y) give `ea = {8'h00, (dp + opnd[7:0] + index) mod 2^16}`, always in bank 0.
- R6: Modes 9 and 10 (absolute plus X, absolute plus Y) give `ea = ({dbr, opnd[15:0]} + index) mod 2^24`, with the carry reaching the bank byte. Mode 11 (long plus X) gives `ea = (opnd + xr) mod 2^24`.
- R7: Pointer reads work as follows:
  - Each pointer byte is requested with `mem_req` at the bank-0 address `{8'h00, (base + i) mod 2^16}`, for i = 0, 1 and, for a 24-bit pointer, 2.
  - Byte i fills pointer bits [8i+7:8i].
  - A byte is taken in a cycle where both `mem_req` and `mem_valid` are high.
  - `mem_addr` holds steady while the read waits.
- R8: Mode 4 reads a 16-bit pointer at base `dp + opnd[7:0]` and gives `ea = ({dbr, ptr} + yr) mod 2^24`.
- R9: Mode 5 reads a 24-bit pointer at base `dp + opnd[7:0]` and gives `ea = (ptr + yr) mod 2^24`.
- R10: Mode 6 reads a 16-bit pointer at base `(dp + opnd[7:0] + xr) mod 2^16` and gives `ea = {dbr, ptr}`.
- R11: `busy` is high from the cycle after an accepted indirect `start` until the last pointer byte is taken. `done` pulses in the next cycle, when `busy` is already low. A `start` while `busy` is high is ignored and produces no result.
- R12: A `start` in the same cycle as `done` is accepted and processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address calculation |
| mode | input | 4 | Addressing-mode code |
| opnd | input | 24 | Operand bytes, low byte first |
| dp | input | 16 | Direct-page base |
| dbr | input | 8 | Data bank |
| pbr | input | 8 | Program bank |
| pc | input | 16 | Program counter at the operand |
| xr | input | 16 | X index |
| yr | input | 16 | Y index |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 24 | Pointer byte address |
| mem_rdata | input | 8 | Returned pointer byte |
| mem_valid | input | 1 | Returned byte is valid |
| ea | output | 24 | Effective address |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Pointer fetch in progress |

## Verification
Two events can fall in the same cycle: the arrival of the final pointer byte and a fresh `start`. A second event pair is a `start` and the `done` of the previous operation. The bench provokes the first pair by raising `start` while a pointer fetch is waiting on the memory responder, whose latency varies from zero to two cycles. That request must leave no extra result in the expected queue. The second pair is provoked by issuing the next operation in exactly the cycle where `done` is seen. Its result, and for indirect modes its pointer addresses, must then match the reference model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_CNT_W = 2;

  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_DIR  = 4'd1,
    M_ABS  = 4'd2,
    M_ABSL = 4'd3,
    M_DIY  = 4'd4,
    M_DIYL = 4'd5,
    M_DXI  = 4'd6,
    M_DPX  = 4'd7,
    M_DPY  = 4'd8,
    M_ABX  = 4'd9,
    M_ABY  = 4'd10,
    M_ALX  = 4'd11
  } ea_mode_e;

  typedef enum logic {S_IDLE, S_FETCH} ea_state_e;
endpackage

// File: rtl/ea_form.sv
module ea_form import ea_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic [3:0]               mode,
  input  logic [ADDR_W-1:0]        opnd,
  input  logic [WORD_W-1:0]        dp,
  input  logic [ADDR_W-WORD_W-1:0] dbr,
  input  logic [ADDR_W-WORD_W-1:0] pbr,
  input  logic [WORD_W-1:0]        pc,
  input  logic [WORD_W-1:0]        xr,
  input  logic [WORD_W-1:0]        yr,
  input  logic [ADDR_W-1:0]        ptr,
  output logic [ADDR_W-1:0]        ea,
  output logic [WORD_W-1:0]        base,
  output logic [EA_CNT_W-1:0]      nbytes
);
  localparam int BANK_W = ADDR_W - WORD_W;

  logic [WORD_W-1:0] dpsum;
  logic [ADDR_W-1:0] absd;
  logic [ADDR_W-1:0] xw, yw;

  assign dpsum = dp + WORD_W'(opnd[7:0]);
  assign absd  = {dbr, opnd[WORD_W-1:0]};
  assign xw    = ADDR_W'(xr);
  assign yw    = ADDR_W'(yr);

  always_comb begin
    base   = dpsum;
    nbytes = '0;
    case (ea_mode_e'(mode))
      M_IMM:  ea = {pbr, pc};
      M_DIR:  ea = {BANK_W'(0), dpsum};
      M_ABS:  ea = absd;
      M_DIY:  begin ea = {dbr, ptr[WORD_W-1:0]} + yw; nbytes = 2'd2; end
      M_DIYL: begin ea = ptr + yw; nbytes = 2'd3; end
      M_DXI:  begin ea = {dbr, ptr[WORD_W-1:0]}; nbytes = 2'd2; base = dpsum + xr; end
      M_DPX:  ea = {BANK_W'(0), WORD_W'(dpsum + xr)};
      M_DPY:  ea = {BANK_W'(0), WORD_W'(dpsum + yr)};
      M_ABX:  ea = absd + xw;
      M_ABY:  ea = absd + yw;
      M_ALX:  ea = opnd + xw;
      default: ea = opnd;
    endcase
  end
endmodule

// File: rtl/ea_fetch.sv
module ea_fetch import ea_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [WORD_W-1:0]   base,
  input  logic [EA_CNT_W-1:0] nbytes,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [7:0]          mem_rdata,
  input  logic                mem_valid,
  output logic [ADDR_W-1:0]   ptr_next,
  output logic                fin,
  output logic                busy
);
  localparam int BANK_W    = ADDR_W - WORD_W;
  localparam int PTR_BYTES = ADDR_W / 8;

  ea_state_e           st;
  logic [EA_CNT_W-1:0] cnt, last;
  logic [WORD_W-1:0]   base_r;
  logic [ADDR_W-1:0]   ptr;
  logic                take;

  assign busy     = (st == S_FETCH);
  assign mem_req  = busy;
  assign mem_addr = {BANK_W'(0), WORD_W'(base_r + WORD_W'(cnt))};
  assign take     = busy && mem_valid;
  assign fin      = take && (cnt == last);

  always_comb begin
    ptr_next = ptr;
    for (int i = 0; i < PTR_BYTES; i++)
      if (take && cnt == EA_CNT_W'(i)) ptr_next[i*8 +: 8] = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      last   <= '0;
      base_r <= '0;
      ptr    <= '0;
    end else if (!busy) begin
      if (go) begin
        st     <= S_FETCH;
        cnt    <= '0;
        last   <= nbytes - 2'd1;
        base_r <= base;
        ptr    <= '0;
      end
    end else if (take) begin
      ptr <= ptr_next;
      cnt <= cnt + 2'd1;
      if (fin) st <= S_IDLE;
    end
  end

  // R7: a pending read keeps its request and address until accepted
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/ea_unit.sv
module ea_unit import ea_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  localparam int BANK_W = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [WORD_W-1:0] dp,
  input  logic [BANK_W-1:0] dbr,
  input  logic [BANK_W-1:0] pbr,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] xr,
  input  logic [WORD_W-1:0] yr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              done,
  output logic              busy
);
  logic [3:0]          mode_r, f_mode;
  logic [BANK_W-1:0]   dbr_r, f_dbr;
  logic [WORD_W-1:0]   yr_r, f_yr;
  logic [ADDR_W-1:0]   ptr_next, f_ea;
  logic [WORD_W-1:0]   f_base;
  logic [EA_CNT_W-1:0] f_nbytes;
  logic                fin, accept, indirect;

  assign f_mode   = busy ? mode_r : mode;
  assign f_dbr    = busy ? dbr_r  : dbr;
  assign f_yr     = busy ? yr_r   : yr;
  assign accept   = start && !busy;
  assign indirect = (f_nbytes != '0);

  ea_form #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_form (
    .mode(f_mode), .opnd(opnd), .dp(dp), .dbr(f_dbr), .pbr(pbr), .pc(pc),
    .xr(xr), .yr(f_yr), .ptr(ptr_next), .ea(f_ea), .base(f_base),
    .nbytes(f_nbytes)
  );

  ea_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk(clk), .rst(rst), .go(accept && indirect), .base(f_base),
    .nbytes(f_nbytes), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .ptr_next(ptr_next),
    .fin(fin), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea     <= '0;
      done   <= 1'b0;
      mode_r <= '0;
      dbr_r  <= '0;
      yr_r   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mode_r <= mode;
        dbr_r  <= dbr;
        yr_r   <= yr;
        if (!indirect) begin
          ea   <= f_ea;
          done <= 1'b1;
        end
      end else if (fin) begin
        ea   <= f_ea;
        done <= 1'b1;
      end
    end
  end

  // R2: modes without a pointer answer on the next cycle
  p_simple_done_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !indirect) |=> done);
  // R11: the last pointer byte yields done with busy released
  p_fin_done_r11: assert property (@(posedge clk) disable iff (rst)
    fin |=> (done && !busy));
  // R11: no result is reported while a fetch is still running
  p_busy_no_done_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);
  // R7: no read request is made outside a fetch
  p_idle_noreq_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

// File: tb/ea_unit_test.sv
module ea_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [23:0] opnd = '0;
  logic [15:0] dp = '0, pc = '0, xr = '0, yr = '0;
  logic [7:0]  dbr = '0, pbr = '0;
  logic        mem_req, mem_valid = 1'b0;
  logic [23:0] mem_addr, ea;
  logic [7:0]  mem_rdata = '0;
  logic        done, busy;

  int checks = 0, failures = 0;
  int lat_sel = 0, wait_n = 0;
  bit finished = 0;
  logic [23:0] exp_q[$];
  logic [23:0] addr_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ea_unit uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opnd(opnd), .dp(dp),
    .dbr(dbr), .pbr(pbr), .pc(pc), .xr(xr), .yr(yr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .ea(ea), .done(done), .busy(busy)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return 8'(a * 37 + (a >> 8) + 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: returns expected address, pointer base and byte count
  function automatic logic [23:0] ref_ea(input int m, output logic [15:0] b,
                                         output int n);
    logic [15:0] d8;
    logic [23:0] p;
    d8 = dp + 16'(opnd[7:0]);
    b = d8; n = 0;
    if (m == 6) b = d8 + xr;
    if (m == 4 || m == 6) n = 2;
    if (m == 5) n = 3;
    p = '0;
    for (int i = 0; i < n; i++) p[i*8 +: 8] = memf(16'(b + 16'(i)));
    case (m)
      0: return {pbr, pc};
      1: return {8'h00, d8};
      2: return {dbr, opnd[15:0]};
      4: return 24'({dbr, p[15:0]} + 24'(yr));
      5: return 24'(p + 24'(yr));
      6: return {dbr, p[15:0]};
      7: return {8'h00, 16'(d8 + xr)};
      8: return {8'h00, 16'(d8 + yr)};
      9: return 24'({dbr, opnd[15:0]} + 24'(xr));
      10: return 24'({dbr, opnd[15:0]} + 24'(yr));
      11: return 24'(opnd + 24'(xr));
      default: return opnd;
    endcase
  endfunction

  // Drive one start at a negedge; queue the expectation if it is accepted
  task automatic issue(input int m, input string tag);
    logic [15:0] b; int n; logic [23:0] e;
    bit acc;
    mode = 4'(m);
    start = 1'b1;
    acc = !busy;
    e = ref_ea(m, b, n);
    if (acc) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
      for (int i = 0; i < n; i++) addr_q.push_back({8'h00, 16'(b + 16'(i))});
    end
    @(negedge clk);
    start = 1'b0;
    if (acc && n == 0) chk(done === 1'b1, {tag, " R2 latency"}, 32'(done), 32'd1);
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && (exp_q.size() != 0 || busy); k++) @(negedge clk);
    @(negedge clk);
  endtask

  // Memory responder with varying latency; also checks pointer byte addresses
  always @(negedge clk) begin
    if (rst) begin
      mem_valid = 1'b0; wait_n = 0;
    end else if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (mem_req) begin
      if (wait_n == 0) begin
        if (addr_q.size() == 0) chk(1'b0, "R7 unexpected read", 32'(mem_addr), 0);
        else begin
          logic [23:0] ea_exp;
          ea_exp = addr_q.pop_front();
          chk(mem_addr === ea_exp, "R7 pointer address", 32'(mem_addr), 32'(ea_exp));
        end
        mem_rdata = memf(mem_addr[15:0]);
        mem_valid = 1'b1;
        lat_sel = (lat_sel + 1) % 3;
        wait_n = lat_sel;
      end else wait_n--;
    end
  end

  // Per-cycle result comparison against the queued model
  always @(negedge clk) begin
    if (!rst && done === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 spurious done", 32'(ea), 0);
      else begin
        logic [23:0] e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(ea === e, t, 32'(ea), 32'(e));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R1 reset flags",
        {29'd0, done, busy, mem_req}, 0);
    chk(ea === 24'd0, "R1 reset ea", 32'(ea), 0);

    pbr = 8'h7E; pc = 16'h8123; issue(0, "R2 immediate");
    dp = 16'h1200; opnd = 24'h000034; issue(1, "R3 direct");
    dp = 16'hFFF0; opnd = 24'h000020; issue(1, "R3 direct wrap");
    dbr = 8'h12; opnd = 24'hABBEEF; issue(2, "R4 absolute");
    opnd = 24'hC0FFEE; issue(3, "R4 absolute long");
    opnd = 24'h123456; issue(13, "R4 reserved code");
    dp = 16'hFF00; opnd = 24'h0000F0; xr = 16'h0020; issue(7, "R5 dp+X wrap");
    yr = 16'h0101; issue(8, "R5 dp+Y");
    dbr = 8'h12; opnd = 24'h00FFFF; xr = 16'h0002; issue(9, "R6 abs+X carry");
    yr = 16'h8000; opnd = 24'h009000; issue(10, "R6 abs+Y carry");
    opnd = 24'hFFFFFF; xr = 16'h0001; issue(11, "R6 long+X wrap");
    drain();

    dp = 16'h0300; opnd = 24'h000010; dbr = 8'h45; yr = 16'hF000;
    issue(4, "R8 indirect+Y");
    drain();
    dp = 16'hFF00; opnd = 24'h0000FE; yr = 16'h0003;
    issue(5, "R9 long indirect+Y, base wrap");
    drain();
    dp = 16'h0000; opnd = 24'h000080; xr = 16'hFF7F; dbr = 8'h09;
    issue(6, "R10 indexed indirect, base wrap");
    drain();

    // R11: a start during a fetch is dropped
    dp = 16'h2000; opnd = 24'h000044; yr = 16'h0011;
    issue(5, "R11 fetch under stray start");
    for (int k = 0; k < 6; k++) begin
      if (busy) begin opnd = 24'h000099; issue(2, "R11 stray"); end
      else @(negedge clk);
    end
    drain();
    chk(exp_q.size() == 0, "R11 stray start produced no result", 32'(exp_q.size()), 0);

    // R12: next start in the done cycle, simple and indirect
    dp = 16'h0500; opnd = 24'h000022; dbr = 8'h33; yr = 16'h0004;
    issue(4, "R12 first indirect");
    for (int k = 0; k < 20 && done !== 1'b1; k++) @(negedge clk);
    opnd = 24'h000077; issue(6, "R12 indirect in done cycle");
    for (int k = 0; k < 20 && done !== 1'b1; k++) @(negedge clk);
    opnd = 24'h004321; issue(9, "R12 simple in done cycle");
    drain();
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R12 all results seen",
        32'(exp_q.size() + addr_q.size()), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule